// File: doc/BRIEF.md
# Sixteen-Pin I/O Port Register Block

This block is the register side of a sixteen-pin general-purpose I/O port. A 32-bit register bus with a word index selects one of seven registers. Writes take effect on the clock edge where the write strobe is high. Reads are combinational from the selected register. Each pin has a four-bit configuration nibble that selects its direction and output style. From the nibbles and the output data latch, the block drives per-pin output value, output enable, open-drain select and a pull-resistor hint toward the pad ring. Pad electrics, drive strength, alternate-function muxing and analog switching belong to the pad ring and are not modelled here.

Software changes output bits in one of three ways:

- a plain data write;
- a single atomic write that sets some bits and clears others;
- a write that only clears bits.

Pin levels come back through a two-flop synchronizer. A three-write key sequence on the lock register freezes the configuration nibbles of the selected pins until the next reset.

Word indices: 0 low configuration, 1 high configuration, 2 input data, 3 output data, 4 set/clear, 5 clear-only, 6 lock.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset every configuration nibble is 4'b0100, so both configuration registers read 0x44444444. The output data, input data and lock registers read 0, and every pin has output enable and pull enable low.
- R2: The nibble of pin p sits in the low configuration register (index 0) for pins 0-7 and in the high one (index 1) for pins 8-15, at bit offset 4*(p mod 8). Nibble bits [1:0] are the direction code and bits [3:2] the style code. Unlocked nibbles read back what was written.
- R3: A direction code of 00 makes the pin an input with output enable low. Style 00 (analog) and style 01 (floating) give pull enable low. Style 10 gives pull enable high, and the pull-up hint then equals the pin's output data bit (1 means up, 0 means down).
- R4: Any non-zero direction code drives output enable high. Open-drain select equals style bit 0 (styles 01 and 11 are open-drain; 00 and 10 are push-pull). The output value of every pin equals its output data bit.
- R5: A write to the output data register (index 2 is input; index 3 is output) loads bits [15:0]. Reads return those bits with the upper half zero.
- R6: A write to the set/clear register (index 4) sets output bits where wdata[15:0] is 1 and clears bits where wdata[31:16] is 1, leaving the others. When both are 1 for a pin, set wins. The register reads 0.
- R7: A write to the clear-only register (index 5) clears the output bits where wdata[15:0] is 1. Its upper half has no effect.
- R8: The input data register (index 2) returns the pin levels two clock edges after they change and ignores writes.
- R9: Three writes to the lock register (index 6) complete the lock: key bit 16 = 1 with mask M, then key = 0 with M, then key = 1 with M. After them the register reads key bit 16 as 1 and M in bits [15:0].
- R10: Once locked, writes to the configuration nibble of a pin in M are ignored, while unlocked pins in the same register still update.
- R11: A key-0 write that does not follow an arming write with the same mask abandons the pending sequence. A key-1 write that does not close a matching sequence starts a new sequence with its own mask. Until a sequence completes, the key bit reads 0 and no pin is locked. Bits [15:0] of the lock register read the last mask written.
- R12: After completion, lock register writes are ignored and the lock holds until reset. Reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the selected register |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the selected register |
| pin_in | input | 16 | Pin levels from the pads (asynchronous) |
| pin_out | output | 16 | Output value per pin |
| pin_oe | output | 16 | Output enable per pin |
| pin_od | output | 16 | Open-drain select per pin |
| pin_pull_en | output | 16 | Pull resistor enable per pin |
| pin_pull_up | output | 16 | Pull direction per pin, 1 = up |

## Verification
The bench aims at these corner cases:

- **Set/clear overlap.** A set/clear write names the same pin in both halves. A design that let clear win would leave that pin at 0.
- **Broken lock sequences.** These come in three orders: a repeated key-0 write, a mask change on the key-0 write, and a mask change on the closing write. A design that counted key writes without matching masks would lock pins that should stay free.
- **Locked and unlocked nibbles in one register.** Random configuration writes hit registers that hold both kinds of pin. They expose a design that freezes the whole register, or none of it.
- **Synchronizer depth and post-reset lock.** The input path is sampled one edge after a pin change, which shows whether a stage is missing. A reset after locking shows whether the lock is sticky beyond reset.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
    localparam int NPINS        = 16;
    localparam int NIB_W        = 4;
    localparam int PINS_PER_CFG = 8;
    localparam int DATA_W       = 32;
    localparam int ADDR_W       = 3;
    localparam int KEY_BIT      = NPINS;
    localparam int CFG_W        = NPINS * NIB_W;
    localparam logic [NIB_W-1:0] NIB_RESET = 4'b0100;

    localparam logic [ADDR_W-1:0] REG_CFG_LO = 3'd0;
    localparam logic [ADDR_W-1:0] REG_CFG_HI = 3'd1;
    localparam logic [ADDR_W-1:0] REG_IN     = 3'd2;
    localparam logic [ADDR_W-1:0] REG_OUT    = 3'd3;
    localparam logic [ADDR_W-1:0] REG_SETCLR = 3'd4;
    localparam logic [ADDR_W-1:0] REG_CLR    = 3'd5;
    localparam logic [ADDR_W-1:0] REG_LOCK   = 3'd6;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_ARMED,
        SEQ_WAIT_KEY,
        SEQ_DONE
    } lock_seq_e;

    typedef struct packed {
        logic [CFG_W-1:0] cfg;
        logic [NPINS-1:0] odr;
    } port_regs_t;

    typedef struct packed {
        lock_seq_e        state;
        logic [NPINS-1:0] mask;
        logic             key;
    } lock_st_t;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] sync_d, sync_q;

    always_comb begin
        sync_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            sync_d[i] = sync_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign dout = sync_q[STAGES-1];
endmodule

// File: rtl/gpio_lock_seq.sv
module gpio_lock_seq
    import gpio_port_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_wr,
    input  logic             lk_key,
    input  logic [NPINS-1:0] lk_mask,
    output logic [NPINS-1:0] locked,
    output logic             key_rd,
    output logic [NPINS-1:0] mask_rd
);
    lock_st_t seq_d, seq_q;
    logic     same_mask;

    assign same_mask = (lk_mask == seq_q.mask);

    always_comb begin
        seq_d = seq_q;
        if (lk_wr && seq_q.state != SEQ_DONE) begin
            seq_d.mask = lk_mask;
            case (seq_q.state)
                SEQ_IDLE:
                    seq_d.state = lk_key ? SEQ_ARMED : SEQ_IDLE;
                SEQ_ARMED:
                    if (!lk_key && same_mask) seq_d.state = SEQ_WAIT_KEY;
                    else if (lk_key)          seq_d.state = SEQ_ARMED;
                    else                      seq_d.state = SEQ_IDLE;
                SEQ_WAIT_KEY:
                    if (lk_key && same_mask) begin
                        seq_d.state = SEQ_DONE;
                        seq_d.key   = 1'b1;
                    end else if (lk_key) begin
                        seq_d.state = SEQ_ARMED;
                    end else begin
                        seq_d.state = SEQ_IDLE;
                    end
                default: seq_d.state = SEQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{state: SEQ_IDLE, mask: '0, key: 1'b0};
        else        seq_q <= seq_d;
    end

    assign locked  = seq_q.key ? seq_q.mask : '0;
    assign key_rd  = seq_q.key;
    assign mask_rd = seq_q.mask;

    AST_KEY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.key |=> seq_q.key) else $error("key bit dropped"); // R12
    AST_MASK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.key |=> $stable(seq_q.mask)) else $error("locked mask changed"); // R12
    AST_KEY_AFTER_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_q.key) |-> ($past(seq_q.state) == SEQ_WAIT_KEY && $past(lk_wr)))
        else $error("key set without sequence"); // R11
endmodule

// File: rtl/gpio_pin_decode.sv
module gpio_pin_decode
    import gpio_port_pkg::*;
(
    input  logic [CFG_W-1:0] cfg,
    input  logic [NPINS-1:0] odr,
    output logic [NPINS-1:0] oe,
    output logic [NPINS-1:0] od,
    output logic [NPINS-1:0] pull_en,
    output logic [NPINS-1:0] pull_up
);
    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        logic [1:0] dir_code;
        logic [1:0] sty_code;
        assign dir_code   = cfg[g*NIB_W +: 2];
        assign sty_code   = cfg[g*NIB_W+2 +: 2];
        assign oe[g]      = |dir_code;
        assign od[g]      = (|dir_code) & sty_code[0];
        assign pull_en[g] = ~(|dir_code) & (sty_code == 2'b10);
        assign pull_up[g] = pull_en[g] & odr[g];
    end
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic [NPINS-1:0]  pin_od,
    output logic [NPINS-1:0]  pin_pull_en,
    output logic [NPINS-1:0]  pin_pull_up
);
    localparam int PAD_W  = DATA_W - NPINS;
    localparam int HALF_W = PINS_PER_CFG * NIB_W;

    port_regs_t       regs_d, regs_q;
    logic [NPINS-1:0] locked;
    logic [NPINS-1:0] idr;
    logic [NPINS-1:0] lock_mask_rd;
    logic             lock_key_rd;
    logic             cfg_wr, sel_hi;

    gpio_in_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk), .rst_n (rst_n), .din (pin_in), .dout (idr)
    );

    gpio_lock_seq u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .lk_wr   (bus_wr && bus_addr == REG_LOCK),
        .lk_key  (bus_wdata[KEY_BIT]),
        .lk_mask (bus_wdata[NPINS-1:0]),
        .locked  (locked),
        .key_rd  (lock_key_rd),
        .mask_rd (lock_mask_rd)
    );

    gpio_pin_decode u_dec (
        .cfg     (regs_q.cfg),
        .odr     (regs_q.odr),
        .oe      (pin_oe),
        .od      (pin_od),
        .pull_en (pin_pull_en),
        .pull_up (pin_pull_up)
    );

    assign cfg_wr = bus_wr && (bus_addr == REG_CFG_LO || bus_addr == REG_CFG_HI);
    assign sel_hi = (bus_addr == REG_CFG_HI);

    always_comb begin
        regs_d = regs_q;
        if (cfg_wr) begin
            for (int p = 0; p < NPINS; p++) begin
                if ((sel_hi == (p >= PINS_PER_CFG)) && !locked[p]) begin
                    regs_d.cfg[p*NIB_W +: NIB_W] =
                        bus_wdata[(p % PINS_PER_CFG)*NIB_W +: NIB_W];
                end
            end
        end
        if (bus_wr) begin
            case (bus_addr)
                REG_OUT:    regs_d.odr = bus_wdata[NPINS-1:0];
                REG_SETCLR: regs_d.odr = (regs_q.odr & ~bus_wdata[DATA_W-1:NPINS])
                                         | bus_wdata[NPINS-1:0];
                REG_CLR:    regs_d.odr = regs_q.odr & ~bus_wdata[NPINS-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.cfg <= {NPINS{NIB_RESET}};
            regs_q.odr <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        case (bus_addr)
            REG_CFG_LO: bus_rdata = regs_q.cfg[HALF_W-1:0];
            REG_CFG_HI: bus_rdata = regs_q.cfg[CFG_W-1:HALF_W];
            REG_IN:     bus_rdata = {{PAD_W{1'b0}}, idr};
            REG_OUT:    bus_rdata = {{PAD_W{1'b0}}, regs_q.odr};
            REG_LOCK:   bus_rdata = {{(PAD_W-1){1'b0}}, lock_key_rd, lock_mask_rd};
            default:    bus_rdata = '0;
        endcase
    end

    assign pin_out = regs_q.odr;

    for (genvar g = 0; g < NPINS; g++) begin : g_lock_chk
        AST_LOCKED_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
            locked[g] |=> $stable(regs_q.cfg[g*NIB_W +: NIB_W]))
            else $error("locked nibble changed"); // R10
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == REG_SETCLR) |=>
        ((regs_q.odr & $past(bus_wdata[NPINS-1:0])) == $past(bus_wdata[NPINS-1:0])))
        else $error("set bit not applied"); // R6
    AST_CLR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == REG_CLR) |=>
        ((regs_q.odr & $past(bus_wdata[NPINS-1:0])) == '0))
        else $error("clear bit not applied"); // R7
    AST_DIR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & pin_pull_en) == '0)
        else $error("pull enabled on driven pin"); // R3
endmodule

// File: tb/sim_gpio_port_regs.sv
`timescale 1ns/1ps
module sim_gpio_port_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_out, pin_oe, pin_od, pin_pull_en, pin_pull_up;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    logic [63:0] m_cfg;
    logic [15:0] m_odr;
    logic [15:0] m_mask;
    logic        m_key;

    always #5 clk = ~clk;

    gpio_port_regs u0 (
        .clk (clk), .rst_n (rst_n), .bus_wr (bus_wr), .bus_addr (bus_addr),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .pin_in (pin_in),
        .pin_out (pin_out), .pin_oe (pin_oe), .pin_od (pin_od),
        .pin_pull_en (pin_pull_en), .pin_pull_up (pin_pull_up)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] e_oe();
        logic [15:0] r;
        for (int p = 0; p < 16; p++) r[p] = (m_cfg[p*4 +: 2] != 2'b00);
        return r;
    endfunction
    function automatic logic [15:0] e_od();
        logic [15:0] r;
        for (int p = 0; p < 16; p++) r[p] = (m_cfg[p*4 +: 2] != 2'b00) && m_cfg[p*4+2];
        return r;
    endfunction
    function automatic logic [15:0] e_pe();
        logic [15:0] r;
        for (int p = 0; p < 16; p++) r[p] = (m_cfg[p*4 +: 2] == 2'b00) && (m_cfg[p*4+2 +: 2] == 2'b10);
        return r;
    endfunction

    task automatic model_reset();
        m_cfg = {16{4'b0100}};
        m_odr = '0;
        m_mask = '0;
        m_key = 1'b0;
    endtask

    task automatic model_apply(input logic [2:0] a, input logic [31:0] d);
        logic [15:0] lk;
        lk = m_key ? m_mask : 16'h0;
        case (a)
            3'd0, 3'd1:
                for (int p = 0; p < 8; p++) begin
                    if (!lk[p + 8*a]) m_cfg[(p + 8*a)*4 +: 4] = d[p*4 +: 4];
                end
            3'd3: m_odr = d[15:0];
            3'd4: m_odr = (m_odr & ~d[31:16]) | d[15:0];
            3'd5: m_odr = m_odr & ~d[15:0];
            3'd6: if (!m_key) m_mask = d[15:0];
            default: ;
        endcase
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        model_apply(a, d);
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic check_all(input string tag);
        logic [31:0] v;
        rd(3'd0, v); chk({tag, " R2 cfg lo"}, v, m_cfg[31:0]);
        rd(3'd1, v); chk({tag, " R2 cfg hi"}, v, m_cfg[63:32]);
        rd(3'd3, v); chk({tag, " R5 out"}, v, {16'h0, m_odr});
        rd(3'd6, v); chk({tag, " R11 lock"}, v, {15'h0, m_key, m_mask});
        chk({tag, " R3 oe"}, {16'h0, pin_oe}, {16'h0, e_oe()});
        chk({tag, " R4 od"}, {16'h0, pin_od}, {16'h0, e_od()});
        chk({tag, " R3 pull_en"}, {16'h0, pin_pull_en}, {16'h0, e_pe()});
        chk({tag, " R3 pull_up"}, {16'h0, pin_pull_up}, {16'h0, e_pe() & m_odr});
        chk({tag, " R4 out"}, {16'h0, pin_out}, {16'h0, m_odr});
    endtask

    task automatic rand_phase(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            logic [2:0] a;
            case ($urandom_range(0, 4))
                0: a = 3'd0;
                1: a = 3'd1;
                2: a = 3'd3;
                3: a = 3'd4;
                default: a = 3'd5;
            endcase
            wr(a, $urandom());
            check_all(tag);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd7321));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(3'd0, v); chk("R1 cfg lo", v, 32'h44444444);
        rd(3'd1, v); chk("R1 cfg hi", v, 32'h44444444);
        rd(3'd3, v); chk("R1 out", v, 32'h0);
        rd(3'd2, v); chk("R1 in", v, 32'h0);
        rd(3'd6, v); chk("R1 lock", v, 32'h0);
        chk("R1 oe", {16'h0, pin_oe}, 32'h0);
        chk("R1 pull_en", {16'h0, pin_pull_en}, 32'h0);

        // R2 R3 R4: directed decode of every style
        wr(3'd0, 32'h8FB61408);
        wr(3'd3, 32'h00000001);
        rd(3'd0, v); chk("R2 readback lo", v, 32'h8FB61408);
        chk("R4 oe directed", {16'h0, pin_oe}, 32'h0078);
        chk("R4 od directed", {16'h0, pin_od}, 32'h0050);
        chk("R3 pull_en directed", {16'h0, pin_pull_en}, 32'h0081);
        chk("R3 pull_up directed", {16'h0, pin_pull_up}, 32'h0001);
        wr(3'd1, 32'h12345678);
        rd(3'd1, v); chk("R2 readback hi", v, 32'h12345678);
        check_all("R2 directed");

        // R5 R6 R7
        wr(3'd3, 32'hFFFFA5C3);
        rd(3'd3, v); chk("R5 out write", v, 32'h0000A5C3);
        wr(3'd4, 32'h0F0F0300);
        rd(3'd3, v); chk("R6 set wins", v, 32'h0000A3C0);
        rd(3'd4, v); chk("R6 reads zero", v, 32'h0);
        wr(3'd5, 32'hFFFF0080);
        rd(3'd3, v); chk("R7 clear only", v, 32'h0000A340);

        // R8: two-edge synchronizer, writes ignored
        @(negedge clk); pin_in = 16'hBEEF;
        @(negedge clk); rd(3'd2, v); chk("R8 one edge", v, 32'h0);
        @(negedge clk); rd(3'd2, v); chk("R8 two edges", v, 32'h0000BEEF);
        wr(3'd2, 32'h00001234);
        rd(3'd2, v); chk("R8 write ignored", v, 32'h0000BEEF);

        rand_phase(150, "rand unlocked");

        // R11: broken sequences
        wr(3'd6, 32'h000100FF); wr(3'd6, 32'h000000FF);
        wr(3'd6, 32'h000000FF); wr(3'd6, 32'h000100FF);
        rd(3'd6, v); chk("R11 repeated key0", v, 32'h000000FF);
        wr(3'd0, 32'h11111111);
        check_all("R11 still free 1");
        wr(3'd6, 32'h000100F0); wr(3'd6, 32'h000000F1); wr(3'd6, 32'h000100F0);
        rd(3'd6, v); chk("R11 mask change key0", v, 32'h000000F0);
        wr(3'd6, 32'h00018001); wr(3'd6, 32'h00008001); wr(3'd6, 32'h00018003);
        rd(3'd6, v); chk("R11 mask change close", v, 32'h00008003);
        wr(3'd0, 32'h22222222);
        check_all("R11 still free 2");

        // R9: proper sequence
        wr(3'd6, 32'h000180F1); wr(3'd6, 32'h000080F1); wr(3'd6, 32'h000180F1);
        m_key = 1'b1;
        rd(3'd6, v); chk("R9 lock complete", v, 32'h000180F1);

        // R10: locked nibbles hold, others update
        wr(3'd0, 32'h0);
        wr(3'd1, 32'h0);
        rd(3'd0, v); chk("R10 lo partial", v, 32'h22220002);
        rd(3'd1, v); chk("R10 hi partial", v, {m_cfg[63:60], 28'h0});
        rand_phase(150, "R10 rand locked");

        // R12: lock register frozen, cleared by reset
        wr(3'd6, 32'h0001FFFF); wr(3'd6, 32'h0000FFFF); wr(3'd6, 32'h0001FFFF);
        rd(3'd6, v); chk("R12 lock frozen", v, 32'h000180F1);
        check_all("R12 after frozen");
        do_reset();
        rd(3'd6, v); chk("R12 reset clears lock", v, 32'h0);
        rd(3'd0, v); chk("R12 reset cfg", v, 32'h44444444);
        wr(3'd0, 32'h00000009);
        rd(3'd0, v); chk("R12 pin0 writable", v, 32'h00000009);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule